// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes the accumulator value, a second operand and a four-bit operation code. It produces an eight-bit result in the same cycle, together with a write strobe that tells the accumulator to capture that result. It also holds a five-flag condition register. That register loads on the rising clock edge when a committed operation is one that affects flags, so the new flags are visible from the following cycle.

All arithmetic goes through one shared adder. Subtraction is done as addition of the inverted operand with a carry-in. The sign, zero and even-parity flags always come from the result byte. The half carry comes from the adder's low nibble. The carry flag is either the adder's carry out or its inverse, which gives a borrow for subtract-type operations. A decoder outside this block asserts `op_valid` when an operation is committed.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes are ADD=0, ADDC=1, SUB=2, SUBB=3, INC=4, DEC=5, AND=6, OR=7, XOR=8, NOT=9, CMP=10, PASS=11. The `result` port is combinational and shows the low eight bits of the operation: a+b, a+b+CY, a-b, a-b-CY, a+1, a-1, a&b, a|b, a^b, ~a, or b for PASS. When `op_valid` is high, `acc_we` is high in the same cycle for every code except CMP.
- R2: CMP (code 10) drives a-b on `result`, keeps `acc_we` low and updates every flag exactly as SUB does.
- R3: After a flag-updating operation, flag byte bit 7 (sign) equals bit 7 of that operation's result.
- R4: After a flag-updating operation, flag byte bit 6 (zero) is 1 exactly when the eight-bit result is 00h.
- R5: Flag byte bit 4 (half carry) is the carry out of bit 3 of the internal sum. That sum is a+b+cin for ADD/ADDC and a+~b+cin for SUB/CMP (cin=1) and SUBB (cin=NOT CY). INC computes a+1 and DEC computes a+FFh.
- R6: Flag byte bit 2 (parity) is 1 when the result has an even number of 1 bits and 0 when the count is odd.
- R7: Flag byte bit 0 (carry) is the carry out of bit 7 for ADD/ADDC. For SUB, SUBB and CMP it is a borrow: it is set when the operand, plus the incoming CY for SUBB, exceeds the accumulator as unsigned values.
- R8: INC and DEC update sign, zero, half carry and parity but leave the carry flag unchanged.
- R9: AND, OR and XOR clear both carry and half carry.
- R10: The flag byte is unchanged after a cycle in which `op_valid` is low or the code is NOT, PASS or 12..15. Codes 12..15 also keep `acc_we` low.
- R11: The flag byte always reads bit 5=0, bit 3=0, bit 1=1. Synchronous `rst` sets it to 02h. A committed update appears on `flags_q` in the cycle after the operation is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_valid | input | 1 | The operation on `op` is committed this cycle |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| operand | input | 8 | Second operand |
| result | output | 8 | Combinational result toward the accumulator |
| acc_we | output | 1 | Accumulator write strobe for this cycle |
| flags_q | output | 8 | Registered flag byte |

## Verification
`result` and `acc_we` are due in the same cycle the inputs are applied. The bench drives inputs on the falling edge and samples these two outputs a nanosecond later. `flags_q` is due one rising edge later, so the bench checks each vector's flags at the next falling edge, just before it drives the following vector. The reference model carries its own copy of the flags forward, so ADDC, SUBB, INC and DEC see whatever carry the previous vector left behind.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 4;
    localparam int FLAG_W = 8;

    localparam int POS_S  = 7;
    localparam int POS_Z  = 6;
    localparam int POS_AC = 4;
    localparam int POS_P  = 2;
    localparam int POS_CY = 0;

    // Flag byte with every live flag cleared; bit 1 is a constant one.
    localparam logic [FLAG_W-1:0] FLAG_FIXED = FLAG_W'(8'h02);

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBB = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_NOT  = 4'd9,
        OP_CMP  = 4'd10,
        OP_PASS = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic half;
        logic par;
        logic carry;
    } flag_t;

    typedef struct packed {
        word_t res;
        flag_t flags;
        logic  wr_acc;
        logic  upd;
    } alu_out_t;

    function automatic logic even_parity(input word_t w);
        return ~^w;
    endfunction

    function automatic logic [FLAG_W-1:0] pack_flags(input flag_t f);
        logic [FLAG_W-1:0] v;
        v         = FLAG_FIXED;
        v[POS_S]  = f.sign;
        v[POS_Z]  = f.zero;
        v[POS_AC] = f.half;
        v[POS_P]  = f.par;
        v[POS_CY] = f.carry;
        return v;
    endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half_out
);
    localparam int HW = NIB + 1;

    logic [W:0]    full;
    logic [HW-1:0] low;

    always_comb begin
        full     = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        low      = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
        sum      = full[W-1:0];
        cout     = full[W];
        half_out = low[NIB];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  word_t           a,
    input  word_t           b,
    input  flag_t           cur,
    output alu_out_t        out
);
    word_t b_eff;
    word_t logic_res;
    word_t sum;
    word_t res;
    logic  cin;
    logic  use_add;
    logic  inv_c;
    logic  keep_cy;
    logic  wr;
    logic  upd;
    logic  cout;
    logic  half;

    always_comb begin
        b_eff     = '0;
        cin       = 1'b0;
        use_add   = 1'b0;
        inv_c     = 1'b0;
        keep_cy   = 1'b0;
        logic_res = '0;
        wr        = 1'b0;
        upd       = 1'b0;
        case (alu_op_e'(op))
            OP_ADD:  begin b_eff = b;  cin = 1'b0;       use_add = 1'b1; wr = 1'b1; upd = 1'b1; end
            OP_ADDC: begin b_eff = b;  cin = cur.carry;  use_add = 1'b1; wr = 1'b1; upd = 1'b1; end
            OP_SUB:  begin b_eff = ~b; cin = 1'b1;       use_add = 1'b1; inv_c = 1'b1; wr = 1'b1; upd = 1'b1; end
            OP_SUBB: begin b_eff = ~b; cin = ~cur.carry; use_add = 1'b1; inv_c = 1'b1; wr = 1'b1; upd = 1'b1; end
            OP_CMP:  begin b_eff = ~b; cin = 1'b1;       use_add = 1'b1; inv_c = 1'b1; upd = 1'b1; end
            OP_INC:  begin b_eff = '0; cin = 1'b1;       use_add = 1'b1; keep_cy = 1'b1; wr = 1'b1; upd = 1'b1; end
            OP_DEC:  begin b_eff = '1; cin = 1'b0;       use_add = 1'b1; keep_cy = 1'b1; wr = 1'b1; upd = 1'b1; end
            OP_AND:  begin logic_res = a & b; wr = 1'b1; upd = 1'b1; end
            OP_OR:   begin logic_res = a | b; wr = 1'b1; upd = 1'b1; end
            OP_XOR:  begin logic_res = a ^ b; wr = 1'b1; upd = 1'b1; end
            OP_NOT:  begin logic_res = ~a;    wr = 1'b1; end
            OP_PASS: begin logic_res = b;     wr = 1'b1; end
            default: begin logic_res = '0; end
        endcase
    end

    alu8_adder #(
        .W   (DATA_W),
        .NIB (NIB_W)
    ) u_add (
        .a        (a),
        .b        (b_eff),
        .cin      (cin),
        .sum      (sum),
        .cout     (cout),
        .half_out (half)
    );

    always_comb begin
        res              = use_add ? sum : logic_res;
        out.res          = res;
        out.wr_acc       = wr;
        out.upd          = upd;
        out.flags.sign   = res[DATA_W-1];
        out.flags.zero   = (res == '0);
        out.flags.par    = even_parity(res);
        out.flags.half   = use_add & half;
        if (keep_cy)
            out.flags.carry = cur.carry;
        else if (use_add)
            out.flags.carry = cout ^ inv_c;
        else
            out.flags.carry = 1'b0;
    end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  flag_t d,
    output flag_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              acc_we,
    output logic [FLAG_W-1:0] flags_q
);
    flag_t    cur_flags;
    alu_out_t core_out;

    alu8_core u_core (
        .op  (op),
        .a   (acc_in),
        .b   (operand),
        .cur (cur_flags),
        .out (core_out)
    );

    alu8_flagreg u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (op_valid & core_out.upd),
        .d    (core_out.flags),
        .q    (cur_flags)
    );

    assign result  = core_out.res;
    assign acc_we  = op_valid & core_out.wr_acc;
    assign flags_q = pack_flags(cur_flags);
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] result,
    input logic              acc_we,
    input logic [FLAG_W-1:0] flags_q
);
    logic flag_op;
    logic logic_op;
    logic step_op;

    always_comb begin
        flag_op  = (op <= OP_W'(OP_XOR)) || (op == OP_W'(OP_CMP));
        logic_op = (op == OP_W'(OP_AND)) || (op == OP_W'(OP_OR)) || (op == OP_W'(OP_XOR));
        step_op  = (op == OP_W'(OP_INC)) || (op == OP_W'(OP_DEC));
    end

    AST_RESET_VALUE: assert property (@(posedge clk) rst |=> flags_q == FLAG_FIXED); // R11

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        (flags_q[5] == 1'b0) && (flags_q[3] == 1'b0) && (flags_q[1] == 1'b1)); // R11

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_W'(OP_CMP)) |-> !acc_we); // R2

    AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && flag_op) |=> flags_q[POS_S] == $past(result[DATA_W-1])); // R3

    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && flag_op) |=> flags_q[POS_Z] == ($past(result) == '0)); // R4

    AST_PARITY_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && flag_op) |=> flags_q[POS_P] == ~^$past(result)); // R6

    AST_STEP_KEEPS_CY: assert property (@(posedge clk) disable iff (rst)
        (op_valid && step_op) |=> flags_q[POS_CY] == $past(flags_q[POS_CY])); // R8

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && logic_op) |=> (flags_q[POS_CY] == 1'b0) && (flags_q[POS_AC] == 1'b0)); // R9

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || !flag_op) |=> $stable(flags_q)); // R10
endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op       (op),
    .result   (result),
    .acc_we   (acc_we),
    .flags_q  (flags_q)
);

// File: tb/alu8_flags_tb.sv
`timescale 1ns/1ps
module alu8_flags_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [3:0] op;
    logic [7:0] acc_in;
    logic [7:0] operand;
    logic [7:0] result;
    logic       acc_we;
    logic [7:0] flags_q;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference flags
    logic m_s, m_z, m_ac, m_p, m_cy;
    logic last_upd;
    string cy_tag;

    always #2.5 clk = ~clk;

    alu8_flags u_dut (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op       (op),
        .acc_in   (acc_in),
        .operand  (operand),
        .result   (result),
        .acc_we   (acc_we),
        .flags_q  (flags_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (op=%0d a=%0h b=%0h)",
                     tag, act, exp, op, acc_in, operand);
        end
    endtask

    task automatic check_flags();
        logic [7:0] e;
        e = {m_s, m_z, 1'b0, m_ac, 1'b0, m_p, 1'b1, m_cy};
        if (!last_upd) begin
            chk(flags_q == e, "R10", flags_q, e);
        end else begin
            chk(flags_q[7] == m_s,  "R3", flags_q[7], m_s);
            chk(flags_q[6] == m_z,  "R4", flags_q[6], m_z);
            chk(flags_q[4] == m_ac, "R5", flags_q[4], m_ac);
            chk(flags_q[2] == m_p,  "R6", flags_q[2], m_p);
            chk(flags_q[0] == m_cy, cy_tag, flags_q[0], m_cy);
            chk({flags_q[5], flags_q[3], flags_q[1]} == 3'b001, "R11", flags_q, e);
        end
    endtask

    task automatic apply(input int o, input int a, input int b, input bit v);
        int    r;
        int    ac;
        int    cy;
        bit    upd;
        bit    wr;
        logic [7:0] r8;
        @(negedge clk);
        check_flags();
        op       = 4'(o);
        acc_in   = 8'(a);
        operand  = 8'(b);
        op_valid = v;
        #1;
        upd = 1'b1; wr = 1'b1; ac = 0; cy = 0; r = 0;
        case (o)
            0:  begin r = a + b;        cy = (r > 255); ac = ((a % 16) + (b % 16)) > 15; end
            1:  begin r = a + b + m_cy; cy = (r > 255); ac = ((a % 16) + (b % 16) + m_cy) > 15; end
            2, 10: begin r = a - b;     cy = (r < 0);   ac = ((a % 16) + 15 - (b % 16) + 1) > 15; end
            3:  begin r = a - b - m_cy; cy = (r < 0);   ac = ((a % 16) + 15 - (b % 16) + 1 - m_cy) > 15; end
            4:  begin r = a + 1;        cy = m_cy;      ac = ((a % 16) == 15); end
            5:  begin r = a - 1;        cy = m_cy;      ac = ((a % 16) != 0); end
            6:  begin r = a & b; end
            7:  begin r = a | b; end
            8:  begin r = a ^ b; end
            9:  begin r = 255 - a; upd = 1'b0; end
            11: begin r = b;       upd = 1'b0; end
            default: begin upd = 1'b0; wr = 1'b0; end
        endcase
        if (o == 10) wr = 1'b0;
        r8 = 8'(r & 255);
        if (!v) begin
            chk(acc_we == 1'b0, "R10", acc_we, 0);
        end else if (o == 10) begin
            chk(acc_we == 1'b0, "R2", acc_we, 0);
            chk(result == r8, "R2", result, r8);
        end else if (o >= 12) begin
            chk(acc_we == 1'b0, "R10", acc_we, 0);
        end else begin
            chk(acc_we == wr, "R1", acc_we, wr);
            chk(result == r8, "R1", result, r8);
        end
        last_upd = v && upd;
        if (last_upd) begin
            m_s  = r8[7];
            m_z  = (r8 == 8'h00);
            m_p  = ~^r8;
            m_ac = ac[0];
            m_cy = cy[0];
            if (o == 4 || o == 5)       cy_tag = "R8";
            else if (o >= 6 && o <= 8)  cy_tag = "R9";
            else                        cy_tag = "R7";
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(flags_q == 8'h02, "R11", flags_q, 8'h02);
        rst = 1'b0;
        m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
        last_upd = 1'b0;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op = '0; acc_in = '0; operand = '0;
        cy_tag = "R7";
        do_reset();
        // R11: reset in the middle of activity restores 02h
        apply(0, 8'hFF, 8'h01, 1'b1);
        apply(8, 8'h00, 8'h00, 1'b1);
        do_reset();
        // R8: INC at FFh wraps to 00h and keeps a set carry
        apply(2, 8'h00, 8'h01, 1'b1);
        apply(4, 8'hFF, 8'h00, 1'b1);
        apply(5, 8'h00, 8'h00, 1'b1);
        for (int o = 0; o < 16; o++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 16; k++) begin
                    apply(o, a, (k * 17 + a / 16) % 256, ((a + k) % 11) != 5);
                end
            end
        end
        @(negedge clk);
        check_flags();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule